// File: doc/BRIEF.md
# Dual-Personality Floppy Controller Bus Glue

This block connects an 8-bit host I/O bus to one floppy disk controller core that is shared between two bus personalities: a high-density one, reached at ports 0x90/0x92/0x94, and a double-density one, reached at ports 0xC8/0xCA/0xCC. A mode register at port 0xBE selects which personality is live. Only the live port set reaches the controller. The same mode bit steers the controller interrupt and DMA request to one of two interrupt lines and one of two DMA channels.

The block holds a control register. A write to it can pulse the controller reset, set the controller ready input, and start a one-shot interval timer. When the timer expires it can raise a single-cycle interrupt on interrupt line 2. The mode register also sets the density type reported for each drive. Bus reads are combinational and return controller data, status constants or mode readback. Every unmatched read returns 0xFF.

Top module: `fdc_glue`

## Requirements
- R1: Ports 0x90 and 0xC8 forward bus writes to the controller with register select 0, and ports 0x92 and 0xCA do the same with register select 1. Address bit 4 is 1 for the 0x90 group and 0 for the 0xC8 group, and a forward happens only when that bit equals mode bit 0. The written byte appears on the controller write data.
- R2: Reads of a live data port raise the controller read strobe with the same register select and return the controller read data. Reads of a data port in the inactive group return 0xFF and raise no strobe.
- R3: A write to the control port of the inactive group (0x94 while mode bit 0 is 0, 0xCC while it is 1) changes nothing. The control register, the ready output and the timer keep their state, and no controller reset is issued.
- R4: A live control write whose data bit 7 is 1, made while the stored control bit 7 is 0, drives the controller reset output high for exactly RST_CYC cycles, starting in the cycle after the write. If stored bit 7 is already 1, no pulse follows.
- R5: A live control write copies data bit 6 to the controller ready output from the next cycle on. A write to 0xCC with data bit 5 clear leaves the ready output unchanged. At 0x94, bit 5 has no such effect.
- R6: A live control write with data bit 0 set starts or restarts a one-shot timer of CLK_KHZ*TIMER_MS cycles. The timer interrupt appears on interrupt line 2 as a one-cycle pulse, exactly that many cycles after the write edge, and only if the stored control bit 2 is set at expiry. A restart cancels the earlier expiry.
- R7: A write to 0xBE stores mode bits [1:0]. A 0-to-1 change of mode bit 1 sets both drive type outputs to high density (1), and a 1-to-0 change sets them to double density (0). A read of 0xBE returns 0xF8 OR mode bits [1:0].
- R8: A read of 0x94 returns 0x44 when mode bit 0 is 1. A read of 0xCC returns 0x64, OR 0x10 when a disk is present, when mode bit 0 is 0. In the other mode these ports read 0xFF.
- R9: A read at any other address, including addresses whose upper byte is nonzero, returns 0xFF.
- R10: With mode bit 0 set, the controller interrupt drives interrupt line 3 and the DMA request drives DMA channel 2. With it clear they drive interrupt line 2 and DMA channel 3. The timer pulse is ORed onto interrupt line 2 in both modes.
- R11: After reset the control register is 0x80, so a later write of 0x80 gives no reset pulse. The mode register is 0x03, so 0xBE reads 0xFB. Both drives are high density, ready is low, the reset output is low, and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 16 | Host I/O address |
| bus_wdata_i | input | 8 | Host write data |
| bus_wr_i | input | 1 | One-cycle write strobe |
| bus_rd_i | input | 1 | One-cycle read strobe |
| bus_rdata_o | output | 8 | Combinational read data |
| fdc_sel_o | output | 1 | Controller register select |
| fdc_wr_o | output | 1 | Controller write strobe |
| fdc_rd_o | output | 1 | Controller read strobe |
| fdc_wdata_o | output | 8 | Controller write data |
| fdc_rdata_i | input | 8 | Controller read data |
| fdc_reset_o | output | 1 | Controller reset pulse |
| fdc_ready_o | output | 1 | Controller ready input |
| drive_hd_o | output | 2 | Per-drive density type, 1 = high density |
| fdc_irq_i | input | 1 | Controller interrupt |
| fdc_drq_i | input | 1 | Controller DMA request |
| disk_present_i | input | 1 | Disk inserted indication |
| irq2_o | output | 1 | Interrupt line 2 |
| irq3_o | output | 1 | Interrupt line 3 |
| drq2_o | output | 1 | DMA channel 2 request |
| drq3_o | output | 1 | DMA channel 3 request |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle, and that every strobe lasts one cycle with address and data stable during it. They also assume the timer length is at least two cycles. Under these conditions the single-cycle timer pulse and the reset-pulse edge checks are well defined. The stimulus changes bus inputs only on the falling clock edge and drops each strobe after one cycle. It runs the timer with a short length, so that expiry, restart and the sampling of the arm bit can each be placed on an exact cycle.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int N_GRP  = 2;
  localparam int GRP_BIT = 4;

  // index 0: high-density group (addr bit 4 = 1), index 1: double-density group
  localparam logic [AW-1:0] GRP_BASE [N_GRP] = '{16'h0090, 16'h00C8};
  localparam logic [AW-1:0] MODE_PORT = 16'h00BE;
  localparam logic [AW-1:0] OFS_SEL1  = 16'h0002;
  localparam logic [AW-1:0] OFS_CTL   = 16'h0004;

  // control bits
  localparam int CB_RST     = 7;
  localparam int CB_RDY     = 6;
  localparam int CB_RDY_EN  = 5;
  localparam int CB_TMR_IRQ = 2;
  localparam int CB_TMR_GO  = 0;
  // mode bits
  localparam int MB_SEL  = 0;
  localparam int MB_DENS = 1;

  localparam logic [DW-1:0] CTRL_RST  = 8'h80;
  localparam logic [1:0]    MODE_RST  = 2'b11;
  localparam logic [DW-1:0] STAT_HD   = 8'h44;
  localparam logic [DW-1:0] STAT_DD   = 8'h64;
  localparam logic [DW-1:0] DISK_BIT  = 8'h10;
  localparam logic [DW-1:0] MODE_FILL = 8'hF8;
  localparam logic [DW-1:0] RD_IDLE   = 8'hFF;

  typedef enum logic [1:0] {
    PK_NONE,
    PK_DATA,
    PK_CTRL,
    PK_MODE
  } port_kind_e;
endpackage

// File: rtl/fdc_port_decode.sv
module fdc_port_decode
  import fdc_glue_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic          mode_sel_i,
  output port_kind_e    kind_o,
  output logic          live_o,
  output logic          sel_o,
  output logic          cc_o
);
  logic [N_GRP-1:0] hit_dat;
  logic [N_GRP-1:0] hit_ctl;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign hit_dat[g] = (addr_i == GRP_BASE[g]) || (addr_i == GRP_BASE[g] + OFS_SEL1);
    assign hit_ctl[g] = (addr_i == GRP_BASE[g] + OFS_CTL);
  end

  always_comb begin
    kind_o = PK_NONE;
    if (|hit_dat)                kind_o = PK_DATA;
    else if (|hit_ctl)           kind_o = PK_CTRL;
    else if (addr_i == MODE_PORT) kind_o = PK_MODE;
  end

  assign live_o = (addr_i[GRP_BIT] == mode_sel_i);
  assign sel_o  = addr_i[1];
  assign cc_o   = hit_ctl[1];
endmodule

// File: rtl/fdc_ctrl_regs.sv
module fdc_ctrl_regs
  import fdc_glue_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int N_DRV   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             cc_i,
  input  logic             mode_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    ctrl_o,
  output logic [1:0]       mode_o,
  output logic             ready_o,
  output logic             fdc_rst_o,
  output logic             tmr_start_o,
  output logic             tmr_arm_o,
  output logic [N_DRV-1:0] drive_hd_o
);
  localparam int RCW = $clog2(RST_CYC + 1);

  logic [DW-1:0]    ctrl_q;
  logic [1:0]       mode_q;
  logic             ready_q;
  logic [RCW-1:0]   rst_cnt_q;
  logic [N_DRV-1:0] drv_q;

  logic rst_trig, rdy_upd, dens_up, dens_dn;

  assign rst_trig = ctrl_we_i && !ctrl_q[CB_RST] && wdata_i[CB_RST];
  // writes to the double-density control port need bit 5 to touch ready
  assign rdy_upd  = ctrl_we_i && !(cc_i && !wdata_i[CB_RDY_EN]);
  assign dens_up  = mode_we_i && !mode_q[MB_DENS] &&  wdata_i[MB_DENS];
  assign dens_dn  = mode_we_i &&  mode_q[MB_DENS] && !wdata_i[MB_DENS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      mode_q  <= MODE_RST;
      ready_q <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q  <= wdata_i;
      if (mode_we_i) mode_q  <= wdata_i[1:0];
      if (rdy_upd)   ready_q <= wdata_i[CB_RDY];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rst_cnt_q <= '0;
    else if (rst_trig)           rst_cnt_q <= RCW'(RST_CYC);
    else if (rst_cnt_q != '0)    rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  for (genvar d = 0; d < N_DRV; d++) begin : g_drv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      drv_q[d] <= 1'b1;
      else if (dens_up) drv_q[d] <= 1'b1;
      else if (dens_dn) drv_q[d] <= 1'b0;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign mode_o      = mode_q;
  assign ready_o     = ready_q;
  assign fdc_rst_o   = (rst_cnt_q != '0);
  assign tmr_start_o = ctrl_we_i && wdata_i[CB_TMR_GO];
  assign tmr_arm_o   = ctrl_q[CB_TMR_IRQ];
  assign drive_hd_o  = drv_q;

  // R3: control register moves only on an accepted control write
  assert_ctrl_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o));
  // R4: a reset pulse only starts from a 0->1 write of bit 7
  assert_rst_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fdc_rst_o) |-> $past(ctrl_we_i && wdata_i[CB_RST] && !ctrl_o[CB_RST]));
  // R5: 0xCC write with bit 5 clear keeps ready
  assert_rdy_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && cc_i && !wdata_i[CB_RDY_EN]) |=> $stable(ready_o));
  // R7: drive types follow the density bit through its edges
  assert_drv_track_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_hd_o == {N_DRV{mode_o[MB_DENS]}});
endmodule

// File: rtl/fdc_oneshot.sv
module fdc_oneshot #(
  parameter int TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic arm_i,
  output logic pulse_o
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (start_i)             cnt_q <= CW'(TICKS);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      // a restart in the final cycle cancels this expiry
      pulse_q <= (cnt_q == CW'(1)) && !start_i && arm_i;
    end
  end

  assign pulse_o = pulse_q;

  // R6: timer interrupt is a single-cycle pulse
  assert_tmr_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/fdc_glue.sv
module fdc_glue
  import fdc_glue_pkg::*;
#(
  parameter int CLK_KHZ  = 250000,
  parameter int TIMER_MS = 100,
  parameter int RST_CYC  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          fdc_sel_o,
  output logic          fdc_wr_o,
  output logic          fdc_rd_o,
  output logic [DW-1:0] fdc_wdata_o,
  input  logic [DW-1:0] fdc_rdata_i,
  output logic          fdc_reset_o,
  output logic          fdc_ready_o,
  output logic [1:0]    drive_hd_o,
  input  logic          fdc_irq_i,
  input  logic          fdc_drq_i,
  input  logic          disk_present_i,
  output logic          irq2_o,
  output logic          irq3_o,
  output logic          drq2_o,
  output logic          drq3_o
);
  localparam int TICKS = CLK_KHZ * TIMER_MS;
  localparam int N_DRV = 2;

  port_kind_e    kind;
  logic          live, sel, is_cc;
  logic [DW-1:0] ctrl_q;
  logic [1:0]    mode_q;
  logic          ctrl_we, mode_we;
  logic          tmr_start, tmr_arm, tmr_pulse;

  fdc_port_decode u_dec (
    .addr_i     (bus_addr_i),
    .mode_sel_i (mode_q[MB_SEL]),
    .kind_o     (kind),
    .live_o     (live),
    .sel_o      (sel),
    .cc_o       (is_cc)
  );

  assign ctrl_we = bus_wr_i && (kind == PK_CTRL) && live;
  assign mode_we = bus_wr_i && (kind == PK_MODE);

  fdc_ctrl_regs #(.RST_CYC(RST_CYC), .N_DRV(N_DRV)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we),
    .cc_i        (is_cc),
    .mode_we_i   (mode_we),
    .wdata_i     (bus_wdata_i),
    .ctrl_o      (ctrl_q),
    .mode_o      (mode_q),
    .ready_o     (fdc_ready_o),
    .fdc_rst_o   (fdc_reset_o),
    .tmr_start_o (tmr_start),
    .tmr_arm_o   (tmr_arm),
    .drive_hd_o  (drive_hd_o)
  );

  fdc_oneshot #(.TICKS(TICKS)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .arm_i   (tmr_arm),
    .pulse_o (tmr_pulse)
  );

  assign fdc_wr_o    = bus_wr_i && (kind == PK_DATA) && live;
  assign fdc_rd_o    = bus_rd_i && (kind == PK_DATA) && live;
  assign fdc_sel_o   = sel;
  assign fdc_wdata_o = bus_wdata_i;

  always_comb begin
    bus_rdata_o = RD_IDLE;
    unique case (kind)
      PK_DATA: if (live) bus_rdata_o = fdc_rdata_i;
      PK_CTRL: if (live) bus_rdata_o = is_cc ? (STAT_DD | (disk_present_i ? DISK_BIT : '0))
                                             : STAT_HD;
      PK_MODE: bus_rdata_o = MODE_FILL | {6'b0, mode_q};
      default: ;
    endcase
  end

  assign irq3_o = mode_q[MB_SEL] && fdc_irq_i;
  assign irq2_o = (!mode_q[MB_SEL] && fdc_irq_i) || tmr_pulse;
  assign drq2_o = mode_q[MB_SEL] && fdc_drq_i;
  assign drq3_o = !mode_q[MB_SEL] && fdc_drq_i;

  // R1: controller strobes only for the live group
  assert_fdc_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fdc_wr_o || fdc_rd_o) |-> (bus_addr_i[GRP_BIT] == mode_q[MB_SEL]));
  // R3: inactive control port write leaves control state alone
  assert_inactive_ctrl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && kind == PK_CTRL && !live) |=> ($stable(ctrl_q) && $stable(fdc_ready_o)));
  // R10: DMA request reaches at most one channel
  assert_drq_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drq2_o && drq3_o));
  // R10: line 3 only in high-density mode
  assert_irq3_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq3_o |-> (mode_q[MB_SEL] && !drq3_o));
endmodule

// File: tb/tb_fdc_glue.sv
module tb_fdc_glue;
  localparam int TICKS = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic        fsel, fwr, frd;
  logic [7:0]  fwdata;
  logic [7:0]  frdata = '0;
  logic        freset, fready;
  logic [1:0]  drv;
  logic        firq = 1'b0, fdrq = 1'b0, disk = 1'b0;
  logic        irq2, irq3, drq2, drq3;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fdc_glue #(.CLK_KHZ(1), .TIMER_MS(TICKS), .RST_CYC(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_rdata_o(rdata),
    .fdc_sel_o(fsel), .fdc_wr_o(fwr), .fdc_rd_o(frd), .fdc_wdata_o(fwdata),
    .fdc_rdata_i(frdata), .fdc_reset_o(freset), .fdc_ready_o(fready),
    .drive_hd_o(drv), .fdc_irq_i(firq), .fdc_drq_i(fdrq), .disk_present_i(disk),
    .irq2_o(irq2), .irq3_o(irq3), .drq2_o(drq2), .drq3_o(drq3)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        rd;
    logic        wr;
    logic [15:0] a;
    logic [7:0]  wd;
    logic [7:0]  frd;
    logic        dk;
    logic [7:0]  erd;
    logic        efw;
    logic        efr;
    logic        esel;
  } vec_t;

  localparam int NV = 21;
  // mode starts at 0x03 (mode bit 0 = 1, high-density group live)
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b1, 1'b0, 16'h0090, 8'h00, 8'hA5, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0}, // R2
    '{4'd2, 1'b1, 1'b0, 16'h0092, 8'h00, 8'h3C, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b1}, // R2
    '{4'd1, 1'b0, 1'b1, 16'h0090, 8'h11, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0}, // R1
    '{4'd1, 1'b0, 1'b1, 16'h0092, 8'h9E, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1}, // R1
    '{4'd1, 1'b0, 1'b1, 16'h00C8, 8'h33, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}, // R1 inactive
    '{4'd2, 1'b1, 1'b0, 16'h00CA, 8'h00, 8'h77, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1}, // R2 inactive
    '{4'd8, 1'b1, 1'b0, 16'h0094, 8'h00, 8'h00, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd8, 1'b1, 1'b0, 16'h00CC, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd7, 1'b1, 1'b0, 16'h00BE, 8'h00, 8'h00, 1'b0, 8'hFB, 1'b0, 1'b0, 1'b1}, // R7
    '{4'd9, 1'b1, 1'b0, 16'h1090, 8'h00, 8'h12, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd9, 1'b1, 1'b0, 16'h0096, 8'h00, 8'h12, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1}, // R9
    '{4'd7, 1'b0, 1'b1, 16'h00BE, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1}, // R7 mode->0
    '{4'd2, 1'b1, 1'b0, 16'h00C8, 8'h00, 8'h5A, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b0}, // R2
    '{4'd2, 1'b1, 1'b0, 16'h00CA, 8'h00, 8'hC3, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b1}, // R2
    '{4'd1, 1'b0, 1'b1, 16'h00CA, 8'h22, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1}, // R1
    '{4'd2, 1'b1, 1'b0, 16'h0090, 8'h00, 8'h66, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}, // R2 inactive
    '{4'd8, 1'b1, 1'b0, 16'h00CC, 8'h00, 8'h00, 1'b0, 8'h64, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd8, 1'b1, 1'b0, 16'h00CC, 8'h00, 8'h00, 1'b1, 8'h74, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd8, 1'b1, 1'b0, 16'h0094, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd7, 1'b1, 1'b0, 16'h00BE, 8'h00, 8'h00, 1'b0, 8'hF8, 1'b0, 1'b0, 1'b1}, // R7
    '{4'd7, 1'b0, 1'b1, 16'h00BE, 8'h03, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1}  // R7 mode->3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // index i: pulse seen in the cycle after the i-th edge following a write
  task automatic watch_irq2(input int n, output int first, output int cnt);
    first = -1; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (irq2) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  task automatic count_rst(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (freset) cnt++;
    end
  endtask

  initial begin
    logic [7:0] r;
    int first, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 drive types", drv, 2'b11);
    chk("R11 ready", fready, 1'b0);
    chk("R11 reset out", freset, 1'b0);
    bus_rd(16'h00BE, r);
    chk("R11 mode readback", r, 8'hFB);
    watch_irq2(TICKS + 20, first, cnt);
    chk("R11 timer idle", cnt, 0);
    bus_wr(16'h0094, 8'h80);
    count_rst(8, cnt);
    chk("R11 ctrl bit7 set at reset", cnt, 0);

    // table walk: R1 R2 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      addr = VECS[v].a; wdata = VECS[v].wd; frdata = VECS[v].frd; disk = VECS[v].dk;
      rd = VECS[v].rd; wr = VECS[v].wr;
      #1;
      if (VECS[v].rd) chk($sformatf("R%0d vec%0d rdata", VECS[v].req, v), rdata, VECS[v].erd);
      chk($sformatf("R%0d vec%0d fdc_wr", VECS[v].req, v), fwr, VECS[v].efw);
      chk($sformatf("R%0d vec%0d fdc_rd", VECS[v].req, v), frd, VECS[v].efr);
      if (VECS[v].efw || VECS[v].efr)
        chk($sformatf("R%0d vec%0d sel", VECS[v].req, v), fsel, VECS[v].esel);
      if (VECS[v].efw)
        chk($sformatf("R1 vec%0d wdata", v), fwdata, VECS[v].wd);
    end
    @(negedge clk); rd = 1'b0; wr = 1'b0;

    // R7 drive density edges
    bus_wr(16'h00BE, 8'h01);
    chk("R7 1->0 gives double density", drv, 2'b00);
    bus_rd(16'h00BE, r);
    chk("R7 readback 01", r, 8'hF9);
    bus_wr(16'h00BE, 8'h01);
    chk("R7 no edge keeps type", drv, 2'b00);
    bus_wr(16'h00BE, 8'h03);
    chk("R7 0->1 gives high density", drv, 2'b11);

    // R4 reset pulse (mode 0x03, port 0x94 live)
    bus_wr(16'h0094, 8'h00);
    bus_wr(16'h0094, 8'h80);
    chk("R4 pulse cycle 1", freset, 1'b1);
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk);
      chk($sformatf("R4 pulse cycle %0d", i), freset, 1'b1);
    end
    @(negedge clk);
    chk("R4 pulse ends", freset, 1'b0);
    bus_wr(16'h0094, 8'h80);
    count_rst(8, cnt);
    chk("R4 no pulse when bit7 already set", cnt, 0);

    // R3 inactive control port
    bus_wr(16'h0094, 8'h00);
    bus_wr(16'h00CC, 8'hE5);
    chk("R3 ready unchanged", fready, 1'b0);
    watch_irq2(TICKS + 20, first, cnt);
    chk("R3 timer not started", cnt, 0);
    bus_wr(16'h0094, 8'h80);
    chk("R3 ctrl still 00 so reset fires", freset, 1'b1);
    idle(6);
    bus_wr(16'h0094, 8'h00);
    bus_wr(16'h00CC, 8'h80);
    count_rst(8, cnt);
    chk("R3 inactive write no reset", cnt, 0);
    bus_wr(16'h0094, 8'h80);
    idle(6);

    // R5 ready
    bus_wr(16'h0094, 8'hC0);
    chk("R5 ready set via 0x94", fready, 1'b1);
    bus_wr(16'h0094, 8'h80);
    chk("R5 0x94 ignores bit5", fready, 1'b0);
    bus_wr(16'h00BE, 8'h02);
    bus_wr(16'h00CC, 8'hE0);
    chk("R5 ready set via 0xCC", fready, 1'b1);
    bus_wr(16'h00CC, 8'h80);
    chk("R5 0xCC bit5 clear holds", fready, 1'b1);
    bus_wr(16'h00CC, 8'hA0);
    chk("R5 0xCC bit5 set clears", fready, 1'b0);

    // R10 routing, mode bit 0 = 0
    @(negedge clk); firq = 1'b1; fdrq = 1'b1; #1;
    chk("R10 dd irq2", irq2, 1'b1);
    chk("R10 dd irq3", irq3, 1'b0);
    chk("R10 dd drq3", drq3, 1'b1);
    chk("R10 dd drq2", drq2, 1'b0);
    @(negedge clk); firq = 1'b0; fdrq = 1'b0;
    // timer on line 2 in double-density mode
    bus_wr(16'h00CC, 8'h85);
    watch_irq2(TICKS + 20, first, cnt);
    chk("R10 timer on irq2 dd mode", cnt, 1);
    bus_wr(16'h00BE, 8'h03);
    @(negedge clk); firq = 1'b1; fdrq = 1'b1; #1;
    chk("R10 hd irq3", irq3, 1'b1);
    chk("R10 hd irq2", irq2, 1'b0);
    chk("R10 hd drq2", drq2, 1'b1);
    chk("R10 hd drq3", drq3, 1'b0);
    @(negedge clk); firq = 1'b0; fdrq = 1'b0;

    // R6 timer
    bus_wr(16'h0094, 8'h85);
    watch_irq2(TICKS + 50, first, cnt);
    chk("R6 expiry cycle", first, TICKS);
    chk("R6 single pulse", cnt, 1);
    bus_wr(16'h0094, 8'h81);
    watch_irq2(TICKS + 50, first, cnt);
    chk("R6 unarmed no pulse", cnt, 0);
    bus_wr(16'h0094, 8'h85);
    idle(40);
    bus_wr(16'h0094, 8'h85);
    watch_irq2(TICKS + 50, first, cnt);
    chk("R6 restart expiry cycle", first, TICKS);
    chk("R6 restart cancels first", cnt, 1);
    bus_wr(16'h0094, 8'h85);
    idle(19);
    bus_wr(16'h0094, 8'h84);
    watch_irq2(TICKS + 20, first, cnt);
    chk("R6 arm without restart", first, TICKS - 21);
    bus_wr(16'h0094, 8'h85);
    idle(19);
    bus_wr(16'h0094, 8'h80);
    watch_irq2(TICKS + 20, first, cnt);
    chk("R6 disarm before expiry", cnt, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule